// File: doc/BRIEF.md
# Cascaded Down-Counter Timer

This block is a single programmable timer that counts down from a loaded value. The count is 32 bits wide and is held as two 16-bit halves. The lower half steps on every counting tick. The upper half steps only when the lower half borrows from it. The counter is clocked by the system clock. It advances only on cycles where a slow, separately generated tick strobe is high, so the counting rate can be far below the system clock rate.

Software writes a start value with a load strobe and selects one of three behaviours for the moment the count is exhausted:
- keep wrapping (free-running),
- restart from the loaded value (periodic),
- park at zero (one-shot).

When the count steps down onto zero, a sticky flag is raised. The interrupt output is that flag gated by an enable. A clear input drops the flag. Each instance keeps all of its own state, so several can run side by side.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 0 and the interrupt output is low.
- R2: The count changes only on a system clock edge where a load is requested, or where both the tick and run inputs are high. Otherwise it holds its value.
- R3: On a counting tick the lower 16 bits decrement by one. The upper 16 bits decrement only on a tick where the lower half is 0x0000, which then wraps to 0xFFFF.
- R4: With mode = 2'b00 (free-running), a counting tick at count 0 gives 0xFFFFFFFF.
- R5: With mode = 2'b01 (periodic), a counting tick at count 0 reloads the most recently loaded value. A periodic run from value v therefore repeats every v+1 ticks.
- R6: With mode[1] = 1 (one-shot, 2'b10 or 2'b11), the count stays at 0 on further ticks.
- R7: A counting tick that moves the count from 1 to 0 sets the flag. The flag stays set until irq_clr is high. The irq output is the flag AND irq_en, and a masked flag is kept.
- R8: A load strobe puts load_val into the count at the next system clock edge, with no tick needed. It takes priority over a tick in the same cycle and never sets the flag, even for a value of 0.
- R9: When an expiry and irq_clr fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slow counting strobe, one system clock wide |
| run_i | input | 1 | Counting enable |
| mode_i | input | 2 | 00 free-running, 01 periodic, 1x one-shot |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 32 | Value to load |
| irq_en_i | input | 1 | Interrupt mask (1 = pass) |
| irq_clr_i | input | 1 | Clear the expiry flag |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two pairs of functions can land on the same edge.

The first pair is an expiry and a software clear of the flag. The bench loads 1 and raises tick and irq_clr together. It expects the interrupt to be high afterwards, and low only after a later clear with no tick.

The second pair is a load and a counting tick. The bench drives both in one cycle and expects exactly the loaded value, with no decrement and no flag.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int CNT_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_SINGLE   = 2'b10,
        MODE_SINGLE_B = 2'b11
    } mode_e;
endpackage

// File: rtl/cdt_half.sv
module cdt_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] val_o,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] val;
    } half_t;

    half_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.val = load_val_i;
        end else if (dec_i) begin
            st_d.val = st_q.val - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign zero_o = (st_q.val == '0);

    // R8: a load lands the exact value one edge later
    a_r8_half_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (val_o == $past(load_val_i)));

    // R2: with neither load nor step the half is frozen
    a_r2_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_i) |=> $stable(val_o));
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic en_i,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)    st_d.flag = 1'b0;
        if (expire_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.flag & en_i;

    // R7: flag persists until a clear arrives
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_i) |=> st_q.flag);

    // R9: an expiry always leaves the flag set, clear or not
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> st_q.flag);

    // R7: a lone clear drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !st_q.flag);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic [1:0]    mode_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          irq_en_i,
    input  logic          irq_clr_i,
    output logic [CW-1:0] count_o,
    output logic          irq_o
);
    localparam int NH = CW / HW;
    localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] reload;
    } top_t;

    top_t st_d, st_q;

    mode_e         mode;
    logic [NH-1:0] zero_h;
    logic [NH-1:0] chain;
    logic [CW-1:0] count;
    logic          all_zero;
    logic          step_raw;
    logic          step;
    logic          reload_now;
    logic          half_load;
    logic [CW-1:0] half_val;
    logic          expire;

    assign mode = mode_e'(mode_i);

    // reload register: captures every software load
    always_comb begin
        st_d = st_q;
        if (load_i) st_d.reload = load_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // step and reload decisions
    always_comb begin
        all_zero   = &zero_h;
        step_raw   = tick_i & run_i & ~load_i;
        reload_now = 1'b0;
        step       = step_raw;
        unique case (mode)
            MODE_FREE:     step = step_raw;
            MODE_PERIODIC: begin
                reload_now = step_raw & all_zero;
                step       = step_raw & ~all_zero;
            end
            default:       step = step_raw & ~all_zero;
        endcase
        half_load = load_i | reload_now;
        half_val  = load_i ? load_val_i : st_q.reload;
        expire    = step_raw & (count == ONE_C);
    end

    assign chain[0] = step;

    for (genvar i = 0; i < NH; i++) begin : g_half
        if (i > 0) begin : g_link
            assign chain[i] = chain[i-1] & zero_h[i-1];
        end
        cdt_half #(.W(HW)) u_half (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (half_load),
            .load_val_i (half_val[i*HW +: HW]),
            .dec_i      (chain[i]),
            .val_o      (count[i*HW +: HW]),
            .zero_o     (zero_h[i])
        );
    end

    cdt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (irq_clr_i),
        .en_i     (irq_en_i),
        .irq_o    (irq_o)
    );

    assign count_o = count;

    // R2: no load and no counting tick means no change
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(tick_i && run_i)) |=> $stable(count_o));

    // R3: upper half frozen while the lower half is nonzero
    if (NH > 1) begin : g_borrow_chk
        a_r3_upper_borrow: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_i && count_o[HW-1:0] != '0)
            |=> (count_o[CW-1:HW] == $past(count_o[CW-1:HW])));
    end

    // R4: free-running wraps to all ones
    a_r4_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && step_raw && count_o == '0) |=> (count_o == '1));

    // R5: periodic reload returns the last loaded value
    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && step_raw && count_o == '0)
        |=> (count_o == $past(st_q.reload)));

    // R6: one-shot parks at zero
    a_r6_single_park: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && !load_i && count_o == '0) |=> (count_o == '0));
endmodule

// File: tb/tb_cdt_timer.sv
`timescale 1ns/1ps
module tb_cdt_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_i, run_i, load_i, irq_en_i, irq_clr_i;
    logic [1:0]  mode_i;
    logic [31:0] load_val_i;
    logic [31:0] count_o;
    logic        irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    cdt_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .mode_i(mode_i), .load_i(load_i), .load_val_i(load_val_i),
        .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .count_o(count_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] v);
        load_val_i = v; load_i = 1'b1; step(); load_i = 1'b0;
    endtask

    task automatic do_tick();
        tick_i = 1'b1; step(); tick_i = 1'b0; step();
    endtask

    task automatic do_clr();
        irq_clr_i = 1'b1; step(); irq_clr_i = 1'b0;
    endtask

    initial begin
        #750000;
        n_err++;
        $display("FAIL watchdog got=hang exp=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_i = 0; run_i = 1; load_i = 0; irq_en_i = 1;
        irq_clr_i = 0; mode_i = 2'b00; load_val_i = '0;
        step(); step();
        rst_n = 1'b1; step();
        chk("R1 count", count_o, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R8 / R2: load without tick, then idle and gated ticks
        do_load(32'h7);
        chk("R8 load no tick", count_o, 32'h7);
        step(); step();
        chk("R2 idle hold", count_o, 32'h7);
        run_i = 1'b0; do_tick(); do_tick();
        chk("R2 tick without run", count_o, 32'h7);
        run_i = 1'b1;

        // R8: load beats tick, load of zero raises no flag
        do_clr();
        tick_i = 1'b1; do_load(32'h9); tick_i = 1'b0;
        chk("R8 load over tick", count_o, 32'h9);
        do_load(32'h0); step();
        chk("R8 zero load no irq", {31'b0, irq_o}, 32'h0);

        // R3 / R4: borrow sweep over half boundaries, free mode
        mode_i = 2'b00;
        foreach (hi_tab[h]) begin end
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 3; l++) begin
                logic [15:0] hv, lv;
                logic [31:0] v;
                hv = (h == 3) ? 16'hFFFF : 16'(h);
                lv = (l == 2) ? 16'hFFFF : 16'(l);
                v  = {hv, lv};
                do_load(v); do_tick();
                chk((v == 0) ? "R4 free wrap" : "R3 cascade", count_o, v - 32'h1);
            end
        end
        do_load(32'h0002_0003);
        for (int k = 0; k < 4; k++) do_tick();
        chk("R3 two-step borrow", count_o, 32'h0001_FFFF);

        // R7: free-mode countdown sweep, flag only at zero
        for (int v = 1; v <= 16; v++) begin
            do_clr(); do_load(32'(v));
            for (int k = 1; k <= v; k++) begin
                do_tick();
                chk("R7 countdown", count_o, 32'(v - k));
                chk("R7 irq timing", {31'b0, irq_o}, (k == v) ? 32'h1 : 32'h0);
            end
        end

        // R7: masking keeps the flag; sticky across ticks; clear drops it
        do_clr(); irq_en_i = 1'b0; do_load(32'h1); do_tick();
        chk("R7 masked", {31'b0, irq_o}, 32'h0);
        irq_en_i = 1'b1; step();
        chk("R7 unmask shows flag", {31'b0, irq_o}, 32'h1);
        do_tick(); do_tick();
        chk("R7 sticky", {31'b0, irq_o}, 32'h1);
        do_clr();
        chk("R7 cleared", {31'b0, irq_o}, 32'h0);

        // R9: expiry and clear in the same cycle
        do_load(32'h1);
        tick_i = 1'b1; irq_clr_i = 1'b1; step(); tick_i = 1'b0; irq_clr_i = 1'b0;
        chk("R9 set wins count", count_o, 32'h0);
        chk("R9 set wins irq", {31'b0, irq_o}, 32'h1);
        do_clr();
        chk("R9 later clear", {31'b0, irq_o}, 32'h0);

        // R5: periodic sweep, count = v - (k mod (v+1))
        mode_i = 2'b01;
        for (int v = 1; v <= 6; v++) begin
            do_load(32'(v));
            for (int k = 1; k <= 2 * (v + 1); k++) begin
                do_tick();
                chk("R5 periodic", count_o, 32'(v - (k % (v + 1))));
            end
        end

        // R6: one-shot, both encodings
        for (int m = 2; m < 4; m++) begin
            mode_i = 2'(m);
            do_load(32'h2);
            for (int k = 0; k < 5; k++) do_tick();
            chk("R6 one-shot park", count_o, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    logic [1:0] hi_tab [2];
endmodule